// File: doc/BRIEF.md
# Streaming Image Gradient Unit

This block computes first-order image gradients on a pixel stream. Unsigned pixels arrive in raster order, at most one per clock, qualified by a valid strobe. The frame has a configurable width and height. The outermost ring of positions is the frame's border and always counts as zero, whatever value is presented there. Each inner position gets three results: a vertical difference, a horizontal difference and the absolute value of their sum. A flag marks the results whose vertical difference is zero, so that a later angle stage can avoid a division by zero.

Two line stores keep the previous two rows. Short three-column shift registers build the 3x3 neighbourhood. One set of subtractors and one absolute-value unit serve every pixel. Results leave with valid, first-of-frame and last-of-row markers at a fixed latency. A start-of-frame strobe on the input realigns the position counters at any time. Without that strobe, frames can follow back to back.

Top module: `img_grad_stream`

## Requirements
- R1: A pixel accepted in row 0, row FRAME_H-1, column 0 or column FRAME_W-1 (0-based) is replaced by zero in every result that uses it, whatever its input value.
- R2: For inner position (h,w), out_gx equals pixel(h+1,w) minus pixel(h-1,w), as a (PIX_W+1)-bit two's-complement value.
- R3: For inner position (h,w), out_gy equals pixel(h,w+1) minus pixel(h,w-1), as a (PIX_W+1)-bit two's-complement value.
- R4: out_mag equals the absolute value of out_gx plus out_gy, as a (PIX_W+2)-bit unsigned value, and never exceeds 2*(2^PIX_W-1).
- R5: out_gx_zero is 1 exactly when out_gx is zero in the same output beat.
- R6: One output beat is produced for each inner position (rows 1..FRAME_H-2, columns 1..FRAME_W-2), in raster order. out_sof is 1 only on position (1,1) and out_eol is 1 only on column FRAME_W-2. Both are 0 whenever out_valid is 0.
- R7: The beat for (h,w) has out_valid high in the cycle after the second rising edge counted from the edge that accepts pixel (h+1,w+1). In every other cycle out_valid is 0, so idle input cycles show up as idle output cycles.
- R8: A pixel accepted with in_sof=1 is taken as position (0,0), even in the middle of a frame, and the following pixels continue from there.
- R9: Without in_sof, the position after (FRAME_H-1, FRAME_W-1) is (0,0), so consecutive frames need no strobe.
- R10: A synchronous reset sets out_valid low and returns the position counters to (0,0), so the next accepted pixel is taken as position (0,0).

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel on in_pix is accepted this cycle |
| in_sof | input | 1 | Accepted pixel is position (0,0) |
| in_pix | input | PIX_W | Unsigned input pixel |
| out_valid | output | 1 | Result beat present |
| out_sof | output | 1 | Beat is inner position (1,1) |
| out_eol | output | 1 | Beat is the last inner column of its row |
| out_gx | output | PIX_W+1 | Signed vertical difference |
| out_gy | output | PIX_W+1 | Signed horizontal difference |
| out_mag | output | PIX_W+2 | Absolute value of gx plus gy |
| out_gx_zero | output | 1 | out_gx is zero |

## Verification
A wrong column or row count appears within one row. The out_eol markers fall in the wrong place, and every later gy mixes pixels from two rows. A stale or misaddressed line store corrupts out_gx from the third row of the frame onward, which is the first row whose vertical neighbours come from those stores. The bench predicts every cycle's output from its own pixel array and compares it beat by beat. It does this across a frame with input gaps, a frame without a start strobe, a mid-frame restart and a mid-frame reset, so any of these faults is reported within a couple of clocks of the first wrong beat.

// File: rtl/img_grad_pkg.sv
package img_grad_pkg;

  // Signed difference of two pixel values.
  function automatic int grad_diff(input int hi, input int lo);
    return hi - lo;
  endfunction

  // Absolute value of the sum of two gradient components.
  function automatic int grad_abs_sum(input int a, input int b);
    int s;
    s = a + b;
    return (s < 0) ? -s : s;
  endfunction

  typedef struct packed {
    logic vld;
    logic sof;
    logic eol;
  } beat_tag_t;

endpackage

// File: rtl/grad_pos_counter.sv
module grad_pos_counter #(
  parameter int FRAME_W = 66,
  parameter int FRAME_H = 130,
  parameter int COL_W   = $clog2(FRAME_W),
  parameter int ROW_W   = $clog2(FRAME_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             is_border
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_H - 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  // A start strobe overrides the running position for the current pixel.
  assign col = in_sof ? '0 : col_q;
  assign row = in_sof ? '0 : row_q;

  assign is_border = (col == '0) || (col == COL_LAST) ||
                     (row == '0) || (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_valid) begin
      if (col == COL_LAST) begin
        col_q <= '0;
        row_q <= (row == ROW_LAST) ? '0 : row + 1'b1;
      end else begin
        col_q <= col + 1'b1;
        row_q <= row;
      end
    end
  end
endmodule

// File: rtl/grad_line_store.sv
module grad_line_store #(
  parameter int PIX_W   = 8,
  parameter int FRAME_W = 66,
  parameter int COL_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [COL_W-1:0] col,
  input  logic [PIX_W-1:0] pix_z,
  output logic [PIX_W-1:0] up_px,
  output logic [PIX_W-1:0] down_px,
  output logic [PIX_W-1:0] left_px,
  output logic [PIX_W-1:0] right_px
);
  localparam int MID_TAPS = 3;
  localparam int OUT_TAPS = 2;

  logic [PIX_W-1:0] row_near [FRAME_W];
  logic [PIX_W-1:0] row_far  [FRAME_W];
  logic [PIX_W-1:0] mid_sr   [MID_TAPS];
  logic [PIX_W-1:0] up_sr    [OUT_TAPS];
  logic [PIX_W-1:0] down_sr  [OUT_TAPS];
  logic [PIX_W-1:0] near_rd, far_rd;

  assign near_rd = row_near[col];
  assign far_rd  = row_far[col];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FRAME_W; i++) begin
        row_near[i] <= '0;
        row_far[i]  <= '0;
      end
      for (int i = 0; i < MID_TAPS; i++) mid_sr[i] <= '0;
      for (int i = 0; i < OUT_TAPS; i++) begin
        up_sr[i]   <= '0;
        down_sr[i] <= '0;
      end
    end else if (in_valid) begin
      row_near[col] <= pix_z;
      row_far[col]  <= near_rd;
      mid_sr[0]     <= near_rd;
      up_sr[0]      <= far_rd;
      down_sr[0]    <= pix_z;
      for (int i = 1; i < MID_TAPS; i++) mid_sr[i] <= mid_sr[i-1];
      for (int i = 1; i < OUT_TAPS; i++) begin
        up_sr[i]   <= up_sr[i-1];
        down_sr[i] <= down_sr[i-1];
      end
    end
  end

  // Window centre sits one column behind the newest sample.
  assign up_px    = up_sr[OUT_TAPS-1];
  assign down_px  = down_sr[OUT_TAPS-1];
  assign right_px = mid_sr[0];
  assign left_px  = mid_sr[MID_TAPS-1];
endmodule

// File: rtl/grad_calc.sv
module grad_calc
  import img_grad_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int DIFF_W = PIX_W + 1,
  parameter int MAG_W  = PIX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  beat_tag_t                tag_in,
  input  logic [PIX_W-1:0]         up_px,
  input  logic [PIX_W-1:0]         down_px,
  input  logic [PIX_W-1:0]         left_px,
  input  logic [PIX_W-1:0]         right_px,
  output beat_tag_t                tag_out,
  output logic signed [DIFF_W-1:0] gx,
  output logic signed [DIFF_W-1:0] gy,
  output logic [MAG_W-1:0]         mag,
  output logic                     gx_zero
);
  int vert_i, horz_i, mag_i;

  always_comb begin
    vert_i = grad_diff(int'(down_px), int'(up_px));
    horz_i = grad_diff(int'(right_px), int'(left_px));
    mag_i  = grad_abs_sum(vert_i, horz_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_out <= '0;
      gx      <= '0;
      gy      <= '0;
      mag     <= '0;
      gx_zero <= 1'b0;
    end else begin
      tag_out <= tag_in;
      gx      <= DIFF_W'(vert_i);
      gy      <= DIFF_W'(horz_i);
      mag     <= MAG_W'(mag_i);
      gx_zero <= (down_px == up_px);
    end
  end
endmodule

// File: rtl/img_grad_stream.sv
module img_grad_stream
  import img_grad_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int FRAME_W = 66,
  parameter int FRAME_H = 130
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [PIX_W-1:0]       in_pix,
  output logic                   out_valid,
  output logic                   out_sof,
  output logic                   out_eol,
  output logic signed [PIX_W:0]  out_gx,
  output logic signed [PIX_W:0]  out_gy,
  output logic [PIX_W+1:0]       out_mag,
  output logic                   out_gx_zero
);
  localparam int COL_W  = $clog2(FRAME_W);
  localparam int ROW_W  = $clog2(FRAME_H);
  localparam int DIFF_W = PIX_W + 1;
  localparam int MAG_W  = PIX_W + 2;
  localparam logic [COL_W-1:0] COL_FIRST_OUT = COL_W'(2);
  localparam logic [ROW_W-1:0] ROW_FIRST_OUT = ROW_W'(2);
  localparam logic [COL_W-1:0] COL_LAST      = COL_W'(FRAME_W - 1);

  logic [COL_W-1:0] cur_col;
  logic [ROW_W-1:0] cur_row;
  logic             cur_border;
  logic [PIX_W-1:0] pix_z;
  logic [PIX_W-1:0] up_px, down_px, left_px, right_px;
  beat_tag_t        win_tag, res_tag;
  logic             win_ready;

  grad_pos_counter #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_pos (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .col(cur_col), .row(cur_row), .is_border(cur_border)
  );

  assign pix_z = cur_border ? '0 : in_pix;

  grad_line_store #(
    .PIX_W(PIX_W), .FRAME_W(FRAME_W), .COL_W(COL_W)
  ) u_lines (
    .clk(clk), .rst(rst), .in_valid(in_valid), .col(cur_col), .pix_z(pix_z),
    .up_px(up_px), .down_px(down_px), .left_px(left_px), .right_px(right_px)
  );

  // The window is complete once the lower-right neighbour has arrived.
  assign win_ready = in_valid && (cur_row >= ROW_FIRST_OUT) &&
                     (cur_col >= COL_FIRST_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_tag <= '0;
    end else begin
      win_tag.vld <= win_ready;
      win_tag.sof <= win_ready && (cur_row == ROW_FIRST_OUT) &&
                     (cur_col == COL_FIRST_OUT);
      win_tag.eol <= win_ready && (cur_col == COL_LAST);
    end
  end

  grad_calc #(
    .PIX_W(PIX_W), .DIFF_W(DIFF_W), .MAG_W(MAG_W)
  ) u_calc (
    .clk(clk), .rst(rst), .tag_in(win_tag),
    .up_px(up_px), .down_px(down_px), .left_px(left_px), .right_px(right_px),
    .tag_out(res_tag), .gx(out_gx), .gy(out_gy), .mag(out_mag),
    .gx_zero(out_gx_zero)
  );

  assign out_valid = res_tag.vld;
  assign out_sof   = res_tag.sof;
  assign out_eol   = res_tag.eol;
endmodule

// File: rtl/img_grad_stream_chk.sv
module img_grad_stream_chk #(
  parameter int PIX_W   = 8,
  parameter int FRAME_W = 66,
  parameter int FRAME_H = 130,
  parameter int COL_W   = $clog2(FRAME_W),
  parameter int ROW_W   = $clog2(FRAME_H)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_sof,
  input logic [COL_W-1:0]      cur_col,
  input logic [ROW_W-1:0]      cur_row,
  input logic                  out_valid,
  input logic                  out_sof,
  input logic                  out_eol,
  input logic signed [PIX_W:0] out_gx,
  input logic [PIX_W+1:0]      out_mag,
  input logic                  out_gx_zero
);
  localparam logic [PIX_W+1:0] MAG_MAX  = (PIX_W+2)'(2 * ((1 << PIX_W) - 1));
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
  localparam logic [COL_W-1:0] COL_ONE  = COL_W'(1);
  localparam logic [COL_W-1:0] COL_TOP  = COL_W'(FRAME_W);
  localparam logic [ROW_W-1:0] ROW_TOP  = ROW_W'(FRAME_H);

  assert_mag_bound_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mag <= MAG_MAX));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_gx_zero == (out_gx == '0)));

  assert_markers_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eol) |-> out_valid);

  assert_beat_from_input_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_restart_advances_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (in_sof || cur_col == COL_ONE));

  assert_col_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_col == COL_LAST) |=> (cur_col == '0));

  assert_pos_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    (cur_col < COL_TOP) && (cur_row < ROW_TOP));
endmodule

bind img_grad_stream img_grad_stream_chk #(
  .PIX_W(PIX_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
  .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
  .cur_col(cur_col), .cur_row(cur_row),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
  .out_gx(out_gx), .out_mag(out_mag), .out_gx_zero(out_gx_zero)
);

// File: tb/img_grad_stream_bench.sv
`timescale 1ns/1ps
module img_grad_stream_bench;
  localparam int PW = 8;
  localparam int FW = 66;
  localparam int FH = 130;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic out_valid, out_sof, out_eol, out_gx_zero;
  logic signed [PW:0] out_gx, out_gy;
  logic [PW+1:0] out_mag;

  img_grad_stream #(.PIX_W(PW), .FRAME_W(FW), .FRAME_H(FH)) u_img_grad_stream (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_gx(out_gx), .out_gy(out_gy), .out_mag(out_mag), .out_gx_zero(out_gx_zero)
  );

  always #2 clk = ~clk;

  typedef struct {
    int due; int gx; int gy; int mag; bit zero; bit sof; bit eol;
  } exp_t;

  exp_t exp_q[$];
  int   frame_px [FH][FW];
  int   m_row = 0, m_col = 0;
  int   cyc = 0;
  int   checks = 0, failures = 0;
  string phase = "R10 reset";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report_fail(string req, int act, int expv);
    failures++;
    $display("FAIL %s [%s] cyc=%0d actual=%0d expected=%0d", req, phase, cyc, act, expv);
  endtask

  // Reference: record the pixel and predict the beat it completes.
  task automatic model_accept(bit sof, int val);
    int h, w, gx, gy, s;
    if (sof) begin m_row = 0; m_col = 0; end
    // R1: border positions count as zero.
    frame_px[m_row][m_col] = (m_row == 0 || m_row == FH-1 || m_col == 0 || m_col == FW-1) ? 0 : val;
    if (m_row >= 2 && m_col >= 2) begin
      exp_t e;
      h = m_row - 1; w = m_col - 1;
      gx = frame_px[h+1][w] - frame_px[h-1][w];
      gy = frame_px[h][w+1] - frame_px[h][w-1];
      s  = gx + gy;
      e.due = cyc + 2; e.gx = gx; e.gy = gy; e.mag = (s < 0) ? -s : s;
      e.zero = (gx == 0); e.sof = (h == 1 && w == 1); e.eol = (w == FW-2);
      exp_q.push_back(e);
    end
    m_col++;
    if (m_col == FW) begin
      m_col = 0;
      m_row = (m_row == FH-1) ? 0 : m_row + 1;
    end
  endtask

  task automatic send(bit sof, int val);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_pix = val[PW-1:0];
    model_accept(sof, val);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
    end
  endtask

  function automatic int pat_mix(int r, int c);
    return (r * 29 + c * 53 + ((r * c) % 17) * 7) % 256;
  endfunction

  function automatic int pat_check(int r, int c);
    return (((r >> 1) + (c >> 1)) & 1) ? 255 : 0;
  endfunction

  // Per-cycle comparison against the reference queue (R2..R7).
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_valid !== 1'b1) report_fail("R7", int'(out_valid), 1);
        else begin
          if (int'(out_gx) != e.gx)   report_fail("R2", int'(out_gx), e.gx);
          if (int'(out_gy) != e.gy)   report_fail("R3", int'(out_gy), e.gy);
          if (int'(out_mag) != e.mag) report_fail("R4", int'(out_mag), e.mag);
          if (out_gx_zero != e.zero)  report_fail("R5", int'(out_gx_zero), int'(e.zero));
          if (out_sof != e.sof)       report_fail("R6", int'(out_sof), int'(e.sof));
          if (out_eol != e.eol)       report_fail("R6", int'(out_eol), int'(e.eol));
        end
      end else begin
        if (out_valid !== 1'b0) report_fail("R7", int'(out_valid), 0);
        if (out_sof || out_eol) report_fail("R6", int'(out_sof || out_eol), 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 200000) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
    exp_q.delete(); m_row = 0; m_col = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: output idle straight after reset.
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) report_fail("R10", int'(out_valid), 0);

    // R1 R2 R3: varied pixels with non-zero border input and input gaps.
    phase = "R1 mixed frame with gaps";
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++) begin
        send(r == 0 && c == 0, pat_mix(r, c));
        if (((r * FW + c) % 5) == 4) idle(1);
      end

    // R9: next frame follows without a start strobe; extreme values for R4.
    phase = "R9 back-to-back frame";
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++)
        send(1'b0, pat_check(r, c));

    // R8: restart in the middle of a flat frame; R5 sees many zero gx.
    phase = "R8 mid-frame restart";
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < FW; c++)
        send(r == 0 && c == 0, 200);
    for (int c = 0; c < 20; c++) send(1'b0, pat_mix(3, c));
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++)
        send(r == 0 && c == 0, (r < 60) ? 200 : pat_mix(c, r));
    idle(4);

    // R10: reset in mid-frame, then a frame without any start strobe.
    phase = "R10 reset then frame";
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < FW; c++)
        send(r == 0 && c == 0, pat_mix(r + 7, c));
    do_reset();
    for (int r = 0; r < FH; r++)
      for (int c = 0; c < FW; c++)
        send(1'b0, pat_mix(r + 3, c + 5));
    idle(6);

    // R6: every predicted beat was seen.
    checks++;
    if (exp_q.size() != 0) report_fail("R6", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule